// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one indivisible memory update on behalf of a register-based virtual machine. A request supplies the target address, the access size, a 32-bit operation code, the value of the source register and the current value of R0. The unit reads the addressed location, computes the new contents, writes them back when the operation calls for it, and then reports the old contents on a write-back port. That port is tagged for either the source register or R0.

The memory side is a single synchronous port with byte enables. Read data returns a fixed number of cycles after the read is issued. A lock output is raised on the read and held until the last access of the sequence, so an arbiter outside the unit can keep every other master off the port between the read and the write. The unit accepts a new request only while it is idle. It finishes each request with a one-cycle completion pulse, and an error flag is raised with that pulse for an illegal request.

Top module: `atomic_rmw_unit`

## Requirements
- R1: `req_size` is 2'b00 for a 32-bit word and 2'b11 for a 64-bit double word. The codes 2'b01 (half word) and 2'b10 (byte) are illegal. An illegal size completes with `err` set and makes no memory access.
- R2: The simple operation codes in `req_op` are 0x00 add, 0x40 or, 0x50 and and 0xa0 xor. Each one writes `old OP src` back to the addressed location, and add wraps around at the operand width.
- R3: Bit 0 of `req_op` is the fetch flag. On a simple operation with the flag set, the completion cycle raises `wb_src_en` with `wb_data` equal to the memory value read before the update. With the flag clear, neither write-back enable rises.
- R4: Exchange (0xe1) writes `req_src` to memory and returns the old memory value with `wb_src_en`.
- R5: Compare-and-exchange (0xf1) writes `req_src` only when the old memory value equals `req_r0`, and issues no write when they differ. In both cases it returns the old value, zero-extended, with `wb_r0_en`, and `wb_src_en` stays low.
- R6: In word mode only the low 32 bits take part in the arithmetic and in the compare. The write uses `mem_be` = 8'h0F, so the upper half of the memory word is left unchanged. The returned value is zero-extended to 64 bits.
- R7: Any other `req_op` value completes with `err` set, makes no memory access and leaves both write-back enables low. This includes exchange or compare-and-exchange without the fetch flag (0xe0, 0xf0), undefined codes, and nonzero bits 31:8.
- R8: A legal request makes exactly one read, followed by at most one write. `mem_lock` is high on every cycle with `mem_req` and on every cycle between the read and the write.
- R9: `done` is a single-cycle pulse per request. `req_ready` is high only while idle.
- R10: After reset, `req_ready` is high and `mem_req`, `done`, `err`, `wb_src_en` and `wb_r0_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Unit is idle and can take a request |
| req_addr | input | ADDR_W | Target address (base plus offset already summed) |
| req_size | input | 2 | Access size code |
| req_op | input | 32 | Operation code with fetch flag in bit 0 |
| req_src | input | DATA_W | Source register value |
| req_r0 | input | DATA_W | R0 value used as the compare operand |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_lock | output | 1 | Hold off all other memory masters |
| mem_addr | output | ADDR_W | Memory address |
| mem_be | output | DATA_W/8 | Byte enables for the write |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid RD_LAT cycles after the read |
| done | output | 1 | Request completed |
| err | output | 1 | Completed request was illegal |
| wb_src_en | output | 1 | Write `wb_data` into the source register |
| wb_r0_en | output | 1 | Write `wb_data` into R0 |
| wb_data | output | DATA_W | Old memory value, zero-extended |

## Verification
The bench targets word-mode add at the carry boundary. If a carry leaked out of the low half, or if the write used all eight byte lanes, the upper half of memory would change. It runs compare-and-exchange where R0 matches memory only in the low 32 bits: a compare done at full width would skip the write. It also covers a genuine mismatch, where a design that wrote anyway, or returned the value to the wrong register, would corrupt memory or a register. Exchange and compare-and-exchange without the fetch flag, an opcode with stray upper bits, and a byte size are each sent as illegal requests. A design that accepted any of them would show a memory access or a changed location.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

   localparam logic [1:0] SZ_WORD  = 2'b00;
   localparam logic [1:0] SZ_DWORD = 2'b11;

   localparam logic [7:0] OPC_ADD  = 8'h00;
   localparam logic [7:0] OPC_OR   = 8'h40;
   localparam logic [7:0] OPC_AND  = 8'h50;
   localparam logic [7:0] OPC_XOR  = 8'ha0;
   localparam logic [7:0] OPC_SWAP = 8'he0;
   localparam logic [7:0] OPC_CAS  = 8'hf0;

   typedef enum logic [2:0] {
      K_ADD, K_OR, K_AND, K_XOR, K_SWAP, K_CAS
   } rmw_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_READ, ST_WAIT, ST_WRITE, ST_DONE
   } rmw_state_e;

endpackage

// File: rtl/atomic_rmw_decode.sv
module atomic_rmw_decode
   import atomic_rmw_pkg::*;
(
   input  logic [31:0] op,
   input  logic [1:0]  size,
   output rmw_kind_e   kind,
   output logic        fetch,
   output logic        wide,
   output logic        illegal
);
   logic op_bad;
   logic size_bad;

   always_comb begin
      kind   = K_ADD;
      op_bad = 1'b0;
      fetch  = op[0];
      unique case (op[7:1])
         OPC_ADD[7:1]:  kind = K_ADD;
         OPC_OR[7:1]:   kind = K_OR;
         OPC_AND[7:1]:  kind = K_AND;
         OPC_XOR[7:1]:  kind = K_XOR;
         OPC_SWAP[7:1]: begin kind = K_SWAP; op_bad = !op[0]; end
         OPC_CAS[7:1]:  begin kind = K_CAS;  op_bad = !op[0]; end
         default:       op_bad = 1'b1;
      endcase
      if (op[31:8] != 24'd0) op_bad = 1'b1;
   end

   assign size_bad = (size != SZ_WORD) && (size != SZ_DWORD);
   assign wide     = (size == SZ_DWORD);
   assign illegal  = op_bad || size_bad;

endmodule

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu
   import atomic_rmw_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              wide,
   input  rmw_kind_e         kind,
   input  logic [DATA_W-1:0] rd,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] r0,
   output logic [DATA_W-1:0] old_val,
   output logic [DATA_W-1:0] new_val,
   output logic              cmp_eq
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] s_op;
   logic [DATA_W-1:0] raw;

   assign mask    = wide ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
   assign old_val = rd & mask;
   assign s_op    = src & mask;
   assign cmp_eq  = (old_val == (r0 & mask));

   always_comb begin
      unique case (kind)
         K_ADD:   raw = old_val + s_op;
         K_OR:    raw = old_val | s_op;
         K_AND:   raw = old_val & s_op;
         K_XOR:   raw = old_val ^ s_op;
         default: raw = s_op;
      endcase
      new_val = raw & mask;
   end

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
   import atomic_rmw_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int RD_LAT = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [1:0]          req_size,
   input  logic [31:0]         req_op,
   input  logic [DATA_W-1:0]   req_src,
   input  logic [DATA_W-1:0]   req_r0,
   output logic                mem_req,
   output logic                mem_we,
   output logic                mem_lock,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                done,
   output logic                err,
   output logic                wb_src_en,
   output logic                wb_r0_en,
   output logic [DATA_W-1:0]   wb_data
);
   localparam int BE_W  = DATA_W / 8;
   localparam int CNT_W = $clog2(RD_LAT + 1);

   initial begin
      assert (DATA_W == 64) else $error("DATA_W must be 64");
      assert (ADDR_W >= 1)  else $error("ADDR_W must be positive");
      assert (RD_LAT >= 1)  else $error("RD_LAT must be at least 1");
   end

   rmw_state_e        state_q;
   rmw_kind_e         kind_d, kind_q;
   logic              fetch_d, wide_d, illegal_d;
   logic              fetch_q, wide_q, err_q, wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] src_q, r0_q, old_q, new_q;
   logic [DATA_W-1:0] old_c, new_c;
   logic              eq_c;
   logic [CNT_W-1:0]  lat_q;
   logic              data_here;

   atomic_rmw_decode u_dec (
      .op      (req_op),
      .size    (req_size),
      .kind    (kind_d),
      .fetch   (fetch_d),
      .wide    (wide_d),
      .illegal (illegal_d)
   );

   atomic_rmw_alu #(.DATA_W(DATA_W)) u_alu (
      .wide    (wide_q),
      .kind    (kind_q),
      .rd      (mem_rdata),
      .src     (src_q),
      .r0      (r0_q),
      .old_val (old_c),
      .new_val (new_c),
      .cmp_eq  (eq_c)
   );

   assign data_here = (lat_q == CNT_W'(RD_LAT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= K_ADD;
         fetch_q <= 1'b0;
         wide_q  <= 1'b0;
         err_q   <= 1'b0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         src_q   <= '0;
         r0_q    <= '0;
         old_q   <= '0;
         new_q   <= '0;
         lat_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               kind_q  <= kind_d;
               fetch_q <= fetch_d;
               wide_q  <= wide_d;
               err_q   <= illegal_d;
               addr_q  <= req_addr;
               src_q   <= req_src;
               r0_q    <= req_r0;
               old_q   <= '0;
               state_q <= illegal_d ? ST_DONE : ST_READ;
            end
            ST_READ: begin
               lat_q   <= '0;
               state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (data_here) begin
                  old_q   <= old_c;
                  new_q   <= new_c;
                  wr_q    <= (kind_q != K_CAS) || eq_c;
                  state_q <= ((kind_q != K_CAS) || eq_c) ? ST_WRITE : ST_DONE;
               end else begin
                  lat_q <= lat_q + 1'b1;
               end
            end
            ST_WRITE: state_q <= ST_DONE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign mem_we    = (state_q == ST_WRITE);
   assign mem_lock  = (state_q == ST_READ) || (state_q == ST_WAIT) || (state_q == ST_WRITE);
   assign mem_addr  = addr_q;
   assign mem_wdata = new_q;
   assign mem_be    = wide_q ? {BE_W{1'b1}} : {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
   assign done      = (state_q == ST_DONE);
   assign err       = done && err_q;
   assign wb_src_en = done && !err_q && fetch_q && (kind_q != K_CAS);
   assign wb_r0_en  = done && !err_q && (kind_q == K_CAS);
   assign wb_data   = old_q;

   // R8: every memory access is covered by the lock
   a_r8_access_locked: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_lock);
   // R8: a write is always preceded by a locked cycle
   a_r8_write_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> $past(mem_lock));
   // R9: completion lasts a single cycle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: an illegal request touched no memory
   a_r7_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!$past(mem_req) && !wb_src_en && !wb_r0_en));
   // R5: at most one write-back target
   a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      !(wb_src_en && wb_r0_en));
   // R6: a word write never enables the upper byte lanes
   a_r6_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !wide_q) |-> (mem_be[BE_W-1:BE_W/2] == '0));

endmodule

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_op = '0;
   logic [63:0] req_src = '0;
   logic [63:0] req_r0 = '0;
   logic        mem_req, mem_we, mem_lock;
   logic [31:0] mem_addr;
   logic [7:0]  mem_be;
   logic [63:0] mem_wdata;
   logic [63:0] mem_rdata;
   logic        done, err, wb_src_en, wb_r0_en;
   logic [63:0] wb_data;

   int checks = 0;
   int fails = 0;
   int n_rd = 0;
   int n_wr = 0;
   int lock_bad = 0;

   logic [63:0] mem [16];
   logic        got_err, got_src, got_r0, ready_busy;
   logic [63:0] got_data;
   int          d_rd, d_wr;

   always #2.5 clk = ~clk;

   atomic_rmw_unit dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_op(req_op),
      .req_src(req_src), .req_r0(req_r0), .mem_req(mem_req), .mem_we(mem_we),
      .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .err(err),
      .wb_src_en(wb_src_en), .wb_r0_en(wb_r0_en), .wb_data(wb_data)
   );

   always @(posedge clk) begin
      if (mem_req && !mem_we) begin
         mem_rdata <= mem[mem_addr[3:0]];
         n_rd <= n_rd + 1;
      end
      if (mem_req && mem_we) begin
         for (int b = 0; b < 8; b++)
            if (mem_be[b]) mem[mem_addr[3:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
         n_wr <= n_wr + 1;
      end
   end

   always @(negedge clk)
      if (rst_n && mem_req && !mem_lock) lock_bad <= lock_bad + 1;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] op,
                      input logic [63:0] src, input logic [63:0] r0);
      int r0c, w0c;
      @(negedge clk);
      r0c = n_rd; w0c = n_wr;
      req_addr = {28'd0, a}; req_size = sz; req_op = op; req_src = src; req_r0 = r0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      ready_busy = req_ready;
      for (int i = 0; i < 20 && !done; i++) @(negedge clk);
      got_err = err; got_src = wb_src_en; got_r0 = wb_r0_en; got_data = wb_data;
      chk("R9 done", {63'd0, done}, 64'd1);
      @(negedge clk);
      chk("R9 done pulse", {63'd0, done}, 64'd0);
      d_rd = n_rd - r0c; d_wr = n_wr - w0c;
   endtask

   task automatic t_reset();
      chk("R10 ready", {63'd0, req_ready}, 64'd1);
      chk("R10 mem_req", {63'd0, mem_req}, 64'd0);
      chk("R10 outputs", {60'd0, done, err, wb_src_en, wb_r0_en}, 64'd0);
   endtask

   task automatic t_add64_nofetch();
      mem[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      run(4'd1, 2'b11, 32'h00, 64'd2, 64'd0);
      chk("R2 add wraps 64", mem[1], 64'd1);
      chk("R3 no fetch no wb", {62'd0, got_src, got_r0}, 64'd0);
      chk("R8 one read one write", {d_rd[31:0], d_wr[31:0]}, {32'd1, 32'd1});
      chk("R9 ready low while busy", {63'd0, ready_busy}, 64'd0);
   endtask

   task automatic t_add32_fetch();
      mem[2] = 64'hAAAA_BBBB_FFFF_FFFF;
      run(4'd2, 2'b00, 32'h01, 64'h1234_5678_0000_0003, 64'd0);
      chk("R6 word add upper kept", mem[2], 64'hAAAA_BBBB_0000_0002);
      chk("R3 fetch src_en", {62'd0, got_src, got_r0}, 64'd2);
      chk("R6 zero-extended old", got_data, 64'h0000_0000_FFFF_FFFF);
   endtask

   task automatic t_logic(input logic [31:0] op, input logic [63:0] exp, input string nm);
      mem[3] = 64'hF0F0_F0F0_0F0F_0F0F;
      run(4'd3, 2'b11, op, 64'hFF00_FF00_FF00_FF00, 64'd0);
      chk(nm, mem[3], exp);
      chk("R3 fetch old", got_data, 64'hF0F0_F0F0_0F0F_0F0F);
      chk("R3 fetch src_en", {63'd0, got_src}, 64'd1);
   endtask

   task automatic t_swap();
      mem[4] = 64'h1111_2222_3333_4444;
      run(4'd4, 2'b11, 32'he1, 64'h5555_6666_7777_8888, 64'd0);
      chk("R4 swap writes src", mem[4], 64'h5555_6666_7777_8888);
      chk("R4 swap returns old", got_data, 64'h1111_2222_3333_4444);
      chk("R4 swap src_en", {62'd0, got_src, got_r0}, 64'd2);
   endtask

   task automatic t_cas();
      mem[5] = 64'hDEAD_BEEF_0000_0001;
      run(4'd5, 2'b11, 32'hf1, 64'h0000_0000_0000_0099, 64'hDEAD_BEEF_0000_0001);
      chk("R5 cas match writes", mem[5], 64'h99);
      chk("R5 cas r0_en", {62'd0, got_src, got_r0}, 64'd1);
      chk("R5 cas old", got_data, 64'hDEAD_BEEF_0000_0001);
      mem[6] = 64'h7777_7777_0000_0042;
      run(4'd6, 2'b00, 32'hf1, 64'h0000_0000_0000_0055, 64'hABCD_0000_0000_0042);
      chk("R6 cas low-half compare", mem[6], 64'h7777_7777_0000_0055);
      chk("R6 cas old zero-ext", got_data, 64'h42);
      mem[7] = 64'h0000_0000_0000_0010;
      run(4'd7, 2'b11, 32'hf1, 64'hFFFF, 64'h11);
      chk("R5 cas mismatch unchanged", mem[7], 64'h10);
      chk("R5 cas mismatch no write", {32'd0, d_wr[31:0]}, 64'd0);
      chk("R5 cas mismatch r0 old", {got_r0, got_src, got_data[61:0]}, {2'b10, 62'h10});
   endtask

   task automatic t_illegal(input logic [1:0] sz, input logic [31:0] op, input string nm);
      mem[8] = 64'hCAFE_F00D_1234_5678;
      run(4'd8, sz, op, 64'd7, 64'hCAFE_F00D_1234_5678);
      chk(nm, {61'd0, got_err, got_src, got_r0}, 64'd4);
      chk({nm, " no access"}, {d_rd[31:0], d_wr[31:0]}, 64'd0);
      chk({nm, " memory kept"}, mem[8], 64'hCAFE_F00D_1234_5678);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = '0;
      mem_rdata = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_add64_nofetch();
      t_add32_fetch();
      t_logic(32'h41, 64'hFFF0_FFF0_FF0F_FF0F, "R2 or");
      t_logic(32'h51, 64'hF000_F000_0F00_0F00, "R2 and");
      t_logic(32'ha1, 64'h0FF0_0FF0_F00F_F00F, "R2 xor");
      t_swap();
      t_cas();
      t_illegal(2'b11, 32'he0, "R7 swap without fetch");
      t_illegal(2'b11, 32'hf0, "R7 cas without fetch");
      t_illegal(2'b11, 32'h10, "R7 undefined code");
      t_illegal(2'b11, 32'h101, "R7 upper bits set");
      t_illegal(2'b10, 32'h00, "R1 byte size");
      t_illegal(2'b01, 32'h01, "R1 half size");
      chk("R8 lock on every access", {32'd0, lock_bad[31:0]}, 64'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule